// File: doc/BRIEF.md
# LIN Slave Transceiver Mode Controller

This block is the digital sequencer of a LIN slave transceiver that also contains the supply regulator for its host microcontroller. It tracks five operating modes: unpowered, fail-safe, normal, silent and sleep. It takes the enable and transmit-data pins, a battery-good comparator, a regulator-output-good comparator, a wake request from the bus wake detector and a free-running time tick. From these it drives the regulator enable, the transmit-path enable, the bus termination enable and the active-low open-drain reset. In fail-safe mode it also turns the transmit-data pin into an output and drives it, together with the receive-data pin, to report why fail-safe was entered.

Every delay counts tick pulses and is set by a parameter. The analog parts of the transceiver (regulation, slope shaping and comparator thresholds) sit outside this block and reach it as clean digital levels. All pins are plain level signals, and no port carries a data stream or uses a handshake.

Top module: `lin_xcvr_modectl`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, the mode is unpowered (code 0). The regulator, termination and transmit path are off, and the reset output is low.
- R2: When battery-good is low at a clock edge, the mode is unpowered after that edge, whatever the previous mode. When battery-good is high in unpowered mode, the next mode is fail-safe (code 1) with the power source recorded.
- R3: The reset output is high only in fail-safe, normal or silent mode. In those modes it is released only after regulator-good has been high for `RST_TICKS` consecutive ticks, and the count restarts whenever regulator-good goes low.
- R4: Once the reset is released, regulator-good must stay low for `DEB_TICKS` ticks before the reset drops. A reset drop in normal (code 2) or silent (code 3) mode moves the block to fail-safe with the power source recorded.
- R5: In fail-safe mode, the block moves to normal once enable has been high with the reset released for `NORM_TICKS` ticks. It never leaves fail-safe for normal while the reset is low.
- R6: In normal mode, a falling enable with transmit-data low enters sleep (code 4) on the next clock.
- R7: In normal mode, a falling enable with transmit-data high opens a selection window of `SEL_TICKS` ticks. Transmit-data going low inside the window enters sleep. A window that expires with transmit-data still high enters silent. Enable returning high closes the window and the block stays in normal.
- R8: The regulator is on in fail-safe, normal and silent modes. The termination is on in fail-safe and normal modes. The transmit path is on only in normal mode with no selection window open.
- R9: In fail-safe mode the transmit-data output is enabled. It drives 0 after a wake and 1 after a power event (battery or regulator undervoltage). The receive-data output is 0 in fail-safe, sleep and unpowered modes, 1 in silent mode, and follows the bus receiver in normal mode.
- R10: A wake request in silent or sleep mode enters fail-safe with the wake source recorded. In silent mode, enable high with no wake request enters normal. Sleep mode ignores enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle time-base pulse |
| bat_ok_i | input | 1 | Battery above undervoltage threshold |
| vcc_ok_i | input | 1 | Regulator output above undervoltage threshold |
| en_i | input | 1 | Enable pin level |
| txd_i | input | 1 | Transmit-data pin level (as input) |
| wake_i | input | 1 | Bus wake detector request |
| bus_rx_i | input | 1 | Bus receiver output (1 = recessive) |
| mode_o | output | 3 | Mode: 0 unpowered, 1 fail-safe, 2 normal, 3 silent, 4 sleep |
| reg_en_o | output | 1 | Regulator enable |
| tx_en_o | output | 1 | Transmit path enable |
| term_en_o | output | 1 | Bus termination enable |
| nres_o | output | 1 | Active-low reset to the microcontroller |
| txd_oe_o | output | 1 | Transmit-data pin driven as output |
| txd_o | output | 1 | Transmit-data pin value when driven |
| rxd_o | output | 1 | Receive-data pin value |

## Verification
Two pairs of events can land in the same clock. A battery loss can coincide with an enable fall that would otherwise select sleep, and a wake request can coincide with enable rising in silent mode. The bench drives both inputs of each pair in one step. It then expects unpowered mode in the first case, and fail-safe with the wake code on the transmit-data pin in the second, both from its per-cycle reference model and from a directed check. A one-tick regulator dip that must not drop the reset is also checked against a long dip that must.

// File: rtl/lxm_pkg.sv
package lxm_pkg;
  typedef enum logic [2:0] {
    M_UNPWR    = 3'd0,
    M_FAILSAFE = 3'd1,
    M_NORMAL   = 3'd2,
    M_SILENT   = 3'd3,
    M_SLEEP    = 3'd4
  } mode_t;

  typedef enum logic {
    SRC_WAKE  = 1'b0,
    SRC_POWER = 1'b1
  } src_t;
endpackage

// File: rtl/lxm_tick_counter.sv
module lxm_tick_counter #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign done_o = !clr_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr_i || done_o) cnt_q <= '0;
    else if (tick_i)         cnt_q <= cnt_q + 1'b1;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/lxm_reset_gen.sv
module lxm_reset_gen #(
  parameter int unsigned RST_TICKS = 4000,
  parameter int unsigned DEB_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic arm_i,
  input  logic vcc_ok_i,
  output logic nres_o
);
  logic rel_q;
  logic rel_done, drop_done;

  lxm_tick_counter #(.LIMIT(RST_TICKS)) u_rel_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr_i(!arm_i || rel_q || !vcc_ok_i),
    .tick_i(tick_i), .done_o(rel_done)
  );

  lxm_tick_counter #(.LIMIT(DEB_TICKS)) u_deb_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr_i(!arm_i || !rel_q || vcc_ok_i),
    .tick_i(tick_i), .done_o(drop_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rel_q <= 1'b0;
    else if (!arm_i)    rel_q <= 1'b0;
    else if (rel_done)  rel_q <= 1'b1;
    else if (drop_done) rel_q <= 1'b0;
  end

  assign nres_o = rel_q && arm_i;

  // R3
  release_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_q) |-> ($past(vcc_ok_i) && $past(arm_i)));
  // R3
  unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> !rel_q);
  // R4
  uv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rel_q) && $past(arm_i)) |-> !$past(vcc_ok_i));
endmodule

// File: rtl/lxm_mode_fsm.sv
module lxm_mode_fsm
  import lxm_pkg::*;
#(
  parameter int unsigned NORM_TICKS = 15,
  parameter int unsigned SEL_TICKS  = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  input  logic  bat_ok_i,
  input  logic  nres_i,
  input  logic  en_i,
  input  logic  txd_i,
  input  logic  wake_i,
  output mode_t mode_o,
  output src_t  src_o,
  output logic  pend_o
);
  mode_t mode_q, mode_d;
  src_t  src_q, src_d;
  logic  pend_q, pend_d;
  logic  en_q;
  logic  norm_done, sel_done;

  lxm_tick_counter #(.LIMIT(NORM_TICKS)) u_norm_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr_i((mode_q != M_FAILSAFE) || !nres_i || !en_i || !bat_ok_i),
    .tick_i(tick_i), .done_o(norm_done)
  );

  lxm_tick_counter #(.LIMIT(SEL_TICKS)) u_sel_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr_i(!pend_q || en_i || !txd_i || !nres_i || !bat_ok_i),
    .tick_i(tick_i), .done_o(sel_done)
  );

  always_comb begin
    mode_d = mode_q;
    src_d  = src_q;
    pend_d = pend_q;
    if (!bat_ok_i) begin
      mode_d = M_UNPWR;
      pend_d = 1'b0;
    end else begin
      case (mode_q)
        M_UNPWR: begin
          mode_d = M_FAILSAFE;
          src_d  = SRC_POWER;
        end
        M_FAILSAFE: if (norm_done) mode_d = M_NORMAL;
        M_NORMAL: begin
          if (!nres_i) begin
            mode_d = M_FAILSAFE;
            src_d  = SRC_POWER;
            pend_d = 1'b0;
          end else if (pend_q) begin
            if (en_i) pend_d = 1'b0;
            else if (!txd_i) begin
              mode_d = M_SLEEP;
              pend_d = 1'b0;
            end else if (sel_done) begin
              mode_d = M_SILENT;
              pend_d = 1'b0;
            end
          end else if (en_q && !en_i) begin
            if (!txd_i) mode_d = M_SLEEP;
            else        pend_d = 1'b1;
          end
        end
        M_SILENT: begin
          if (!nres_i) begin
            mode_d = M_FAILSAFE;
            src_d  = SRC_POWER;
          end else if (wake_i) begin
            mode_d = M_FAILSAFE;
            src_d  = SRC_WAKE;
          end else if (en_i) begin
            mode_d = M_NORMAL;
          end
        end
        M_SLEEP: if (wake_i) begin
          mode_d = M_FAILSAFE;
          src_d  = SRC_WAKE;
        end
        default: mode_d = M_UNPWR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_UNPWR;
      src_q  <= SRC_POWER;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      src_q  <= src_d;
      pend_q <= pend_d;
      en_q   <= en_i;
    end
  end

  assign mode_o = mode_q;
  assign src_o  = src_q;
  assign pend_o = pend_q;

  // R2
  lost_battery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bat_ok_i |=> (mode_q == M_UNPWR));
  // R6
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_NORMAL && !pend_q && nres_i && bat_ok_i && en_q && !en_i && !txd_i)
      |=> (mode_q == M_SLEEP));
  // R10
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SLEEP && bat_ok_i && !wake_i) |=> (mode_q == M_SLEEP));
  // R5
  fs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FAILSAFE && !nres_i) |=> (mode_q != M_NORMAL));
endmodule

// File: rtl/lin_xcvr_modectl.sv
module lin_xcvr_modectl
  import lxm_pkg::*;
#(
  parameter int unsigned RST_TICKS  = 4000,
  parameter int unsigned DEB_TICKS  = 5,
  parameter int unsigned NORM_TICKS = 15,
  parameter int unsigned SEL_TICKS  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       bat_ok_i,
  input  logic       vcc_ok_i,
  input  logic       en_i,
  input  logic       txd_i,
  input  logic       wake_i,
  input  logic       bus_rx_i,
  output logic [2:0] mode_o,
  output logic       reg_en_o,
  output logic       tx_en_o,
  output logic       term_en_o,
  output logic       nres_o,
  output logic       txd_oe_o,
  output logic       txd_o,
  output logic       rxd_o
);
  mode_t mode;
  src_t  src;
  logic  pend;
  logic  arm;
  logic  nres;

  assign arm = (mode == M_FAILSAFE) || (mode == M_NORMAL) || (mode == M_SILENT);

  lxm_reset_gen #(.RST_TICKS(RST_TICKS), .DEB_TICKS(DEB_TICKS)) u_rst (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .arm_i(arm), .vcc_ok_i(vcc_ok_i), .nres_o(nres)
  );

  lxm_mode_fsm #(.NORM_TICKS(NORM_TICKS), .SEL_TICKS(SEL_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .bat_ok_i(bat_ok_i), .nres_i(nres), .en_i(en_i), .txd_i(txd_i),
    .wake_i(wake_i), .mode_o(mode), .src_o(src), .pend_o(pend)
  );

  always_comb begin
    mode_o    = mode;
    reg_en_o  = arm;
    term_en_o = (mode == M_FAILSAFE) || (mode == M_NORMAL);
    tx_en_o   = (mode == M_NORMAL) && !pend;
    nres_o    = nres;
    txd_oe_o  = (mode == M_FAILSAFE);
    txd_o     = (src == SRC_POWER);
    case (mode)
      M_NORMAL: rxd_o = bus_rx_i;
      M_SILENT: rxd_o = 1'b1;
      default:  rxd_o = 1'b0;
    endcase
  end

  // R9
  wake_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLEEP && bat_ok_i && wake_i) |=> (txd_oe_o && !txd_o && !rxd_o));
endmodule

// File: tb/tb_lin_xcvr_modectl.sv
module tb_lin_xcvr_modectl;
  localparam int RST = 4, DEB = 2, NRM = 3, SEL = 2;

  logic clk = 0, rst_n = 0, tick = 0;
  logic bat = 0, vcc = 0, en = 0, txd = 1, wake = 0, bus = 1;
  logic [2:0] mode;
  logic reg_en, tx_en, term_en, nres, txd_oe, txd_out, rxd;

  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  lin_xcvr_modectl #(.RST_TICKS(RST), .DEB_TICKS(DEB), .NORM_TICKS(NRM), .SEL_TICKS(SEL)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bat_ok_i(bat), .vcc_ok_i(vcc),
    .en_i(en), .txd_i(txd), .wake_i(wake), .bus_rx_i(bus),
    .mode_o(mode), .reg_en_o(reg_en), .tx_en_o(tx_en), .term_en_o(term_en),
    .nres_o(nres), .txd_oe_o(txd_oe), .txd_o(txd_out), .rxd_o(rxd)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 tick <= (cyc % 3 == 0);
  end

  // reference model
  int m_mode = 0, m_src = 1, m_rc = 0, m_dc = 0, m_nc = 0, m_sc = 0;
  bit m_rel = 0, m_pend = 0, m_enq = 0;

  always @(posedge clk) begin
    bit arm, nr, ndone, sdone;
    int nm, ns;
    bit np;
    if (!rst_n) begin
      m_mode = 0; m_src = 1; m_rc = 0; m_dc = 0; m_nc = 0; m_sc = 0;
      m_rel = 0; m_pend = 0; m_enq = 0;
    end else begin
      arm = (m_mode == 1 || m_mode == 2 || m_mode == 3);
      nr  = arm && m_rel;
      ndone = 0; sdone = 0;
      if (m_mode != 1 || !nr || !en || !bat) m_nc = 0;
      else if (tick) begin
        if (m_nc == NRM - 1) begin ndone = 1; m_nc = 0; end else m_nc++;
      end
      if (!m_pend || en || !txd || !nr || !bat) m_sc = 0;
      else if (tick) begin
        if (m_sc == SEL - 1) begin sdone = 1; m_sc = 0; end else m_sc++;
      end
      nm = m_mode; ns = m_src; np = m_pend;
      if (!bat) begin nm = 0; np = 0; end
      else if (m_mode == 0) begin nm = 1; ns = 1; end
      else if (m_mode == 1) begin if (ndone) nm = 2; end
      else if (m_mode == 2) begin
        if (!nr) begin nm = 1; ns = 1; np = 0; end
        else if (m_pend) begin
          if (en) np = 0;
          else if (!txd) begin nm = 4; np = 0; end
          else if (sdone) begin nm = 3; np = 0; end
        end else if (m_enq && !en) begin
          if (!txd) nm = 4; else np = 1;
        end
      end else if (m_mode == 3) begin
        if (!nr) begin nm = 1; ns = 1; end
        else if (wake) begin nm = 1; ns = 0; end
        else if (en) nm = 2;
      end else if (m_mode == 4) begin
        if (wake) begin nm = 1; ns = 0; end
      end
      // reset generator
      if (!arm) begin m_rel = 0; m_rc = 0; m_dc = 0; end
      else if (!m_rel) begin
        m_dc = 0;
        if (!vcc) m_rc = 0;
        else if (tick) begin
          if (m_rc == RST - 1) begin m_rel = 1; m_rc = 0; end else m_rc++;
        end
      end else begin
        m_rc = 0;
        if (vcc) m_dc = 0;
        else if (tick) begin
          if (m_dc == DEB - 1) begin m_rel = 0; m_dc = 0; end else m_dc++;
        end
      end
      m_mode = nm; m_src = ns; m_pend = np; m_enq = en;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    bit e_reg;
    e_reg = (m_mode == 1 || m_mode == 2 || m_mode == 3);
    chk("R2 mode vs model", mode, m_mode);
    chk("R3 nres vs model", nres, e_reg && m_rel);
    chk("R8 reg_en", reg_en, e_reg);
    chk("R8 term_en", term_en, (m_mode == 1 || m_mode == 2));
    chk("R8 tx_en", tx_en, (m_mode == 2 && !m_pend));
    chk("R9 txd_oe", txd_oe, (m_mode == 1));
    chk("R9 txd code", txd_out, m_src);
    chk("R9 rxd", rxd, (m_mode == 2) ? bus : (m_mode == 3));
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    // R1 reset state
    step(3);
    chk("R1 mode in reset", mode, 0);
    chk("R1 nres in reset", nres, 0);
    chk("R1 reg_en in reset", reg_en, 0);
    rst_n = 1;
    step(1);
    chk("R1 mode after reset", mode, 0);
    // R2 battery up -> fail-safe, power code
    bat = 1;
    step(2);
    chk("R2 fail-safe entry", mode, 1);
    chk("R9 power code txd", txd_out, 1);
    chk("R9 txd driven", txd_oe, 1);
    // R5 fail-safe held while reset low, then normal
    en = 1;
    step(20);
    chk("R5 held without vcc", mode, 1);
    chk("R3 nres low without vcc", nres, 0);
    vcc = 1;
    step(40);
    chk("R5 normal reached", mode, 2);
    chk("R3 nres released", nres, 1);
    bus = 0; step(1);
    chk("R9 rxd follows bus", rxd, 0);
    bus = 1;
    // R4 short dip ignored
    vcc = 0; step(1); vcc = 1; step(5);
    chk("R4 short dip", nres, 1);
    // R7 window expires -> silent
    en = 0; txd = 1;
    step(20);
    chk("R7 silent", mode, 3);
    chk("R9 rxd silent", rxd, 1);
    chk("R8 term off silent", term_en, 0);
    // R10 silent en -> normal
    en = 1; step(5);
    chk("R10 silent to normal", mode, 2);
    // R7 enable returns inside window
    en = 0; step(1); en = 1; step(10);
    chk("R7 window cancel", mode, 2);
    // R7 late txd -> sleep
    en = 0; step(1); txd = 0; step(3);
    chk("R7 late txd sleep", mode, 4);
    chk("R8 reg off sleep", reg_en, 0);
    chk("R3 nres low sleep", nres, 0);
    // R10 sleep ignores enable
    en = 1; txd = 1; step(15);
    chk("R10 sleep ignores en", mode, 4);
    // R10 wake from sleep, en still high -> normal after reset
    wake = 1; step(1); wake = 0; step(1);
    chk("R10 wake fail-safe", mode, 1);
    chk("R9 wake code", txd_out, 0);
    step(40);
    chk("R5 normal after wake", mode, 2);
    // R4 long dip -> fail-safe, power code
    vcc = 0; step(20);
    chk("R4 uv fail-safe", mode, 1);
    chk("R4 power code", txd_out, 1);
    vcc = 1; step(40);
    chk("R5 back to normal", mode, 2);
    // R6 simultaneous fall
    en = 0; txd = 0; step(2);
    chk("R6 sleep", mode, 4);
    wake = 1; step(1); wake = 0; en = 0; txd = 1; step(40);
    chk("R10 wake stays fs en low", mode, 1);
    en = 1; step(20);
    chk("R5 normal again", mode, 2);
    // coincidence: battery loss with sleep-selecting enable fall
    en = 0; txd = 0; bat = 0; step(2);
    chk("R2 battery wins", mode, 0);
    bat = 1; txd = 1; en = 1; step(60);
    chk("R5 normal after power-up", mode, 2);
    en = 0; step(20);
    chk("R7 silent again", mode, 3);
    // coincidence: wake and enable rise in silent
    wake = 1; en = 1; step(1); wake = 0; step(1);
    chk("R10 wake beats enable", mode, 1);
    chk("R9 wake code silent", txd_out, 0);
    step(10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule